// File: doc/BRIEF.md
# Multi-Ring Completion Interrupt Coalescer

This block sits beside a set of work rings and collects their completion events. Each ring keeps its own tally and turns it into interrupt requests, so the CPU is not interrupted once per completed item. A ring asks for service in one of two cases. The first is when its tally reaches the count programmed for it. The second is when its own deadline timer runs out while at least one completion is still unreported. A ring with nothing unreported never asks for service, however much time passes.

Requests from all rings share one output channel. The channel presents a ring index under a valid/ready handshake. A round-robin arbiter chooses which pending ring is shown next. Each ring's count limit and deadline are written through a small write port that selects the ring by index. A ring holds at most one request at a time. Further completions on that ring are folded into the request it already has.

Top module: `ring_irq_coalescer`

## Requirements
- R1: With a count limit of N (N≥1), a completion strobe sampled at clock edge E that brings a ring's tally to N makes irqValid high with irqRing equal to that ring after edge E+1, and not before.
- R2: With a deadline of T and a count limit that has not been reached, a ring whose first completion after a clear is sampled at edge E raises its request after edge E+T+1, and not after edge E+T.
- R3: A ring that has no unreported completion never raises a request, whatever its deadline value (including 0).
- R4: A configuration write (cfgWrEn high at an edge) loads cfgThresh and cfgTimeout into the ring that cfgRing selects, and no other ring's settings change.
- R5: A programmed count limit of 0 behaves exactly like a limit of 1.
- R6: A handshake transfer (irqValid and irqReady both high at an edge) clears the served ring's tally and timer. A completion on that ring sampled at the same edge is kept as the first count of the next window.
- R7: While a ring's request is outstanding, more completions on that ring raise no second request. After the transfer, no request follows unless new completions arrive.
- R8: When several rings are pending, they are served in round-robin order. The search starts at the ring after the one most recently transferred. After reset, ring 0 has the highest priority.
- R9: While irqValid is high and irqReady is low, irqValid stays high and irqRing does not change, even if other rings become pending.
- R10: A deadline of 0xFFFF is a legal setting and fires after the full 65536-cycle wait.
- R11: After reset no request is pending, every ring's count limit is 1 and every ring's deadline is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmplStb | input | NUM_RINGS | One completion strobe per ring, one event per high cycle |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgRing | input | RING_W | Ring selected by the configuration write |
| cfgThresh | input | CNT_W | Count limit to store |
| cfgTimeout | input | TMR_W | Deadline in cycles to store |
| irqValid | output | 1 | An interrupt request is presented |
| irqReady | input | 1 | Consumer accepts the presented request |
| irqRing | output | RING_W | Ring index of the presented request |

## Verification
The bench uses the default parameters: 32 rings, a 16-bit count field and a 16-bit deadline field. With these values, ring indices near the wrap point of the round-robin search (rings 30, 0 and 1) are reachable. A single full 0xFFFF deadline can also run to expiry inside the cycle budget, which checks the wide end of the timer and not only small deadline values. The exact edge on which a request appears is checked for both the count path and the deadline path. Handshake stalls are checked while a ring that would otherwise win the arbitration becomes pending.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // Widest ring index carried on the control strobe bundle (up to 1024 rings).
  localparam int unsigned IDX_MAX_W = 10;

  // Strobes from the arbitration control to the per-ring datapath.
  typedef struct packed {
    logic                 accept;   // handshake transfer this cycle
    logic [IDX_MAX_W-1:0] ringIdx;  // ring being served
  } coalStrobe_t;

endpackage

// File: rtl/coal_ring_cell.sv
module coal_ring_cell #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgThresh,
  input  logic [TMR_W-1:0] cfgTimeout,
  input  logic             served,
  output logic             pend,
  output logic             busy
);

  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [CNT_W-1:0] thrQ;
  logic [TMR_W-1:0] toQ;
  logic [CNT_W-1:0] cntQ;
  logic [TMR_W-1:0] elapQ;
  logic             pendQ;

  logic [CNT_W-1:0] thrEff;
  logic             hasWork;
  logic             countHit;
  logic             timeHit;
  logic             fire;

  always_comb begin
    thrEff   = (thrQ == '0) ? ONE_CNT : thrQ;
    hasWork  = (cntQ != '0);
    countHit = (cntQ >= thrEff);
    timeHit  = (elapQ >= toQ);
    fire     = !pendQ && hasWork && (countHit || timeHit);
  end

  // Settings per ring
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thrQ <= ONE_CNT;
      toQ  <= '1;
    end else if (cfgLoad) begin
      thrQ <= cfgThresh;
      toQ  <= cfgTimeout;
    end
  end

  // Tally, deadline timer and request flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ  <= '0;
      elapQ <= '0;
      pendQ <= 1'b0;
    end else if (served) begin
      cntQ  <= cmpl ? ONE_CNT : '0;
      elapQ <= '0;
      pendQ <= 1'b0;
    end else begin
      if (cmpl && (cntQ != '1)) begin
        cntQ <= cntQ + ONE_CNT;
      end
      if (hasWork && !pendQ && (elapQ != '1)) begin
        elapQ <= elapQ + TMR_W'(1);
      end
      if (fire) begin
        pendQ <= 1'b1;
      end
    end
  end

  assign pend = pendQ;
  assign busy = hasWork;

endmodule

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 32,
  parameter int unsigned RING_W    = 5,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TMR_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] cmplStb,
  input  logic                 cfgWrEn,
  input  logic [RING_W-1:0]    cfgRing,
  input  logic [CNT_W-1:0]     cfgThresh,
  input  logic [TMR_W-1:0]     cfgTimeout,
  input  coalStrobe_t          ctl,
  output logic [NUM_RINGS-1:0] pendVec,
  output logic [NUM_RINGS-1:0] busyVec
);

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    logic cfgHit;
    logic servedHit;

    assign cfgHit    = cfgWrEn && (cfgRing == RING_W'(i));
    assign servedHit = ctl.accept && (ctl.ringIdx == IDX_MAX_W'(i));

    coal_ring_cell #(
      .CNT_W(CNT_W),
      .TMR_W(TMR_W)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmpl      (cmplStb[i]),
      .cfgLoad   (cfgHit),
      .cfgThresh (cfgThresh),
      .cfgTimeout(cfgTimeout),
      .served    (servedHit),
      .pend      (pendVec[i]),
      .busy      (busyVec[i])
    );
  end

endmodule

// File: rtl/coal_arbiter.sv
module coal_arbiter
  import coal_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 32,
  parameter int unsigned RING_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] pendVec,
  input  logic                 irqReady,
  output logic                 irqValid,
  output logic [RING_W-1:0]    irqRing,
  output coalStrobe_t          ctl
);

  localparam logic [RING_W-1:0] LAST_IDX = RING_W'(NUM_RINGS - 1);

  logic [RING_W-1:0] ptrQ;      // most recently served ring
  logic              lockQ;     // stalled offer must be held
  logic [RING_W-1:0] lockIdxQ;

  logic [RING_W-1:0] pick;
  logic [RING_W-1:0] grantIdx;
  logic              found;
  logic              xfer;

  // Round-robin search starting just after the last served ring
  always_comb begin
    int unsigned cand;
    logic [RING_W-1:0] candIdx;
    pick  = ptrQ;
    found = 1'b0;
    for (int k = 1; k <= int'(NUM_RINGS); k++) begin
      cand    = (int'(ptrQ) + k) % NUM_RINGS;
      candIdx = RING_W'(cand);
      if (!found && pendVec[candIdx]) begin
        found = 1'b1;
        pick  = candIdx;
      end
    end
  end

  always_comb begin
    grantIdx    = lockQ ? lockIdxQ : pick;
    irqValid    = lockQ || found;
    irqRing     = grantIdx;
    xfer        = irqValid && irqReady;
    ctl.accept  = xfer;
    ctl.ringIdx = IDX_MAX_W'(grantIdx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ     <= LAST_IDX;
      lockQ    <= 1'b0;
      lockIdxQ <= '0;
    end else if (xfer) begin
      ptrQ  <= grantIdx;
      lockQ <= 1'b0;
    end else if (irqValid) begin
      lockQ    <= 1'b1;
      lockIdxQ <= grantIdx;
    end
  end

endmodule

// File: rtl/ring_irq_coalescer.sv
module ring_irq_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned NUM_RINGS = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TMR_W     = 16,
  localparam int unsigned RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] cmplStb,
  input  logic                 cfgWrEn,
  input  logic [RING_W-1:0]    cfgRing,
  input  logic [CNT_W-1:0]     cfgThresh,
  input  logic [TMR_W-1:0]     cfgTimeout,
  output logic                 irqValid,
  input  logic                 irqReady,
  output logic [RING_W-1:0]    irqRing
);

  coalStrobe_t          ctl;
  logic [NUM_RINGS-1:0] pendVec;
  logic [NUM_RINGS-1:0] busyVec;

  coal_datapath #(
    .NUM_RINGS(NUM_RINGS),
    .RING_W   (RING_W),
    .CNT_W    (CNT_W),
    .TMR_W    (TMR_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmplStb   (cmplStb),
    .cfgWrEn   (cfgWrEn),
    .cfgRing   (cfgRing),
    .cfgThresh (cfgThresh),
    .cfgTimeout(cfgTimeout),
    .ctl       (ctl),
    .pendVec   (pendVec),
    .busyVec   (busyVec)
  );

  coal_arbiter #(
    .NUM_RINGS(NUM_RINGS),
    .RING_W   (RING_W)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pendVec (pendVec),
    .irqReady(irqReady),
    .irqValid(irqValid),
    .irqRing (irqRing),
    .ctl     (ctl)
  );

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int unsigned NUM_RINGS = 32,
  parameter int unsigned RING_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irqValid,
  input logic                 irqReady,
  input logic [RING_W-1:0]    irqRing,
  input logic [NUM_RINGS-1:0] pendVec,
  input logic [NUM_RINGS-1:0] busyVec
);

  // R9: a stalled offer keeps its ring index
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irqValid && !irqReady) |=> (irqValid && $stable(irqRing)));

  // R8: the arbiter only offers a ring that holds a request
  p_offer_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqValid |-> pendVec[irqRing]);

  // R6: a transfer retires the served ring's request
  p_xfer_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irqValid && irqReady) |=> !pendVec[$past(irqRing)]);

  // R11: nothing is offered in the first cycle out of reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> !irqValid);

  // R3: a request only appears on a ring that had completions
  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_chk
    p_need_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pendVec[i]) |-> $past(busyVec[i]));
  end

endmodule

bind ring_irq_coalescer coal_checker #(
  .NUM_RINGS(NUM_RINGS),
  .RING_W   (RING_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irqValid(irqValid),
  .irqReady(irqReady),
  .irqRing (irqRing),
  .pendVec (pendVec),
  .busyVec (busyVec)
);

// File: tb/tb_ring_irq_coalescer.sv
`timescale 1ns/1ps
module tb_ring_irq_coalescer;

  localparam int unsigned NR = 32;
  localparam int unsigned RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] cmplStb = '0;
  logic          cfgWrEn = 1'b0;
  logic [RW-1:0] cfgRing = '0;
  logic [15:0]   cfgThresh = '0;
  logic [15:0]   cfgTimeout = '0;
  logic          irqValid;
  logic          irqReady = 1'b0;
  logic [RW-1:0] irqRing;

  int vectors = 0;
  int miscomp = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_irq_coalescer dut (
    .clk(clk), .rst_n(rst_n), .cmplStb(cmplStb),
    .cfgWrEn(cfgWrEn), .cfgRing(cfgRing), .cfgThresh(cfgThresh),
    .cfgTimeout(cfgTimeout), .irqValid(irqValid), .irqReady(irqReady),
    .irqRing(irqRing)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ring, input int thr, input int to);
    cfgWrEn = 1'b1; cfgRing = RW'(ring);
    cfgThresh = 16'(thr); cfgTimeout = 16'(to);
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [NR-1:0] mask);
    cmplStb = mask;
    tick();
    cmplStb = '0;
  endtask

  task automatic take(input int ring, input string tag);
    chk({tag, " valid"}, 32'(irqValid), 1);
    chk({tag, " ring"}, 32'(irqRing), 32'(ring));
    irqReady = 1'b1;
    tick();
    irqReady = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 idle after reset", 32'(irqValid), 0);
    pulse(NR'(1) << 5);
    chk("R11 no early request", 32'(irqValid), 0);
    tick();
    take(5, "R11 default limit 1");
  endtask

  task automatic t_thresh();
    cfg(3, 4, 1000);
    repeat (3) pulse(NR'(1) << 3);
    repeat (2) tick();
    chk("R1 below limit", 32'(irqValid), 0);
    pulse(NR'(1) << 3);
    chk("R1 latency edge", 32'(irqValid), 0);
    tick();
    take(3, "R1 limit reached");
    chk("R1 cleared", 32'(irqValid), 0);
  endtask

  task automatic t_timeout();
    cfg(7, 10, 20);
    pulse(NR'(1) << 7);
    repeat (20) tick();
    chk("R2 before deadline", 32'(irqValid), 0);
    tick();
    take(7, "R2 deadline");
  endtask

  task automatic t_idle();
    cfg(9, 5, 0);
    repeat (50) tick();
    chk("R3 no work no request", 32'(irqValid), 0);
    pulse(NR'(1) << 9);
    tick();
    take(9, "R3 deadline 0 with work");
  endtask

  task automatic t_cfg();
    cfg(12, 3, 16'hFFFF);
    pulse(NR'(1) << 13);
    tick();
    take(13, "R4 neighbour unchanged");
    pulse(NR'(1) << 12);
    pulse(NR'(1) << 12);
    repeat (3) tick();
    chk("R4 new limit held", 32'(irqValid), 0);
    pulse(NR'(1) << 12);
    tick();
    take(12, "R4 new limit");
  endtask

  task automatic t_zero();
    cfg(20, 0, 16'hFFFF);
    pulse(NR'(1) << 20);
    tick();
    take(20, "R5 zero as one");
  endtask

  task automatic t_same();
    cfg(2, 2, 16'hFFFF);
    pulse(NR'(1) << 2);
    pulse(NR'(1) << 2);
    tick();
    chk("R6 offered", 32'(irqValid), 1);
    chk("R6 ring", 32'(irqRing), 2);
    irqReady = 1'b1;
    cmplStb = NR'(1) << 2;
    tick();
    irqReady = 1'b0;
    cmplStb = '0;
    chk("R6 retired", 32'(irqValid), 0);
    repeat (10) tick();
    chk("R6 carried count alone", 32'(irqValid), 0);
    pulse(NR'(1) << 2);
    tick();
    take(2, "R6 carried count kept");
  endtask

  task automatic t_one();
    pulse(NR'(1) << 4);
    tick();
    chk("R7 offered", 32'(irqValid), 1);
    repeat (3) pulse(NR'(1) << 4);
    take(4, "R7 single offer");
    repeat (5) tick();
    chk("R7 no second request", 32'(irqValid), 0);
  endtask

  task automatic t_rr();
    pulse((NR'(1) << 1) | (NR'(1) << 6) | (NR'(1) << 30));
    tick();
    take(6, "R8 first after 4");
    take(30, "R8 second");
    take(1, "R8 wrap");
    chk("R8 drained", 32'(irqValid), 0);
    pulse(NR'(1) | (NR'(1) << 4) | (NR'(1) << 30));
    tick();
    take(4, "R8 after 1");
    take(30, "R8 next");
    take(0, "R8 wrap to 0");
  endtask

  task automatic t_stall();
    pulse(NR'(1) << 10);
    tick();
    chk("R9 offer", 32'(irqRing), 10);
    pulse(NR'(1) << 1);
    repeat (2) tick();
    chk("R9 still valid", 32'(irqValid), 1);
    chk("R9 index held", 32'(irqRing), 10);
    take(10, "R9 held served");
    take(1, "R9 later ring");
  endtask

  task automatic t_long();
    cfg(15, 2, 16'hFFFF);
    pulse(NR'(1) << 15);
    repeat (65535) tick();
    chk("R10 before full wait", 32'(irqValid), 0);
    tick();
    take(15, "R10 full wait");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    t_reset();
    t_thresh();
    t_timeout();
    t_idle();
    t_cfg();
    t_zero();
    t_same();
    t_one();
    t_rr();
    t_stall();
    t_long();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscomp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

endmodule